// File: doc/BRIEF.md
# Transmit Keying Burst Sequencer

This block runs the timing of one transmit burst in a half-duplex data radio. When a burst is requested, it first shifts the synthesizer channel word out over three lines: serial data, serial clock and a latch enable. It then waits for the loop to settle and raises the transmitter key, which also enables the power-amplifier bias.

While the key is up, the burst moves through four phases:
- a quiet phase with no modulation;
- a symbol-sync preamble;
- the payload phase, which lasts until the modem flags the end of its data;
- a tail phase, after which the key is released.

All phase lengths are counted in pulses of a millisecond tick input. Typical settings are a 2 ms settle, a quiet and a tail of 5 ticks each, and a preamble of 12 ticks.

An independent watchdog counts ticks while the key is up. It forces the key off once the programmed limit is reached, so a payload that never ends cannot hold the transmitter on. Each burst ends with a one-cycle done pulse and a status bit that tells a normal end from a forced abort. The current phase code and a phase-change strobe let the modem line up symbol generation.

Top module: `tx_key_seq`

## Requirements
- R1: After reset the phase code is 0 (idle), and key, bias, modulation, payload, done, abort, strobe and all three serial lines are low.
- R2: A burst begins with a 24-bit serial load of `pll_word_i`, MSB first. Each bit lasts two clocks: serial clock low in the first and high in the second, with the data held for both. The enable stays low during the shift and then goes high for exactly two clocks with the data low. The load phase lasts 50 clocks.
- R3: After the load, the settle phase lasts `settle_ms_i` ticks; the key rises only out of the settle phase.
- R4: The quiet phase (code 3) lasts `quiet_ms_i` ticks with the key high and `mod_en_o` low.
- R5: The sync phase (code 4) lasts `sync_ms_i` ticks with `mod_en_o` high and `pay_en_o` low.
- R6: The payload phase (code 5) holds `pay_en_o` and `mod_en_o` high until `data_end_i` is seen high, then enters the tail.
- R7: The tail phase (code 6) lasts `tail_ms_i` ticks; the key then drops. `done_o` pulses for one clock in the first key-low cycle, and `abort_o` is 0.
- R8: If the key has been up for `max_tx_ms_i` ticks, it is forced off. Done pulses in the first key-low cycle with `abort_o` 1, and exactly `max_tx_ms_i` ticks fall inside key-up cycles.
- R9: The request is ignored while a burst is active. After a normal end, a request still high starts a new burst. After an abort, no burst starts until the request has been low and then high again.
- R10: `phase_o` encodes idle 0, load 1, settle 2, quiet 3, sync 4, payload 5, tail 6. `phase_stb_o` is high for one clock in the first cycle of every new phase and at no other time.
- R11: `pa_bias_o` equals `key_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-clock pulse per millisecond |
| req_i | input | 1 | Burst request, level |
| data_end_i | input | 1 | Payload finished |
| pll_word_i | input | 24 | Synthesizer channel word |
| settle_ms_i | input | 8 | Load-to-key delay, ticks |
| quiet_ms_i | input | 8 | Quiet phase length, ticks |
| sync_ms_i | input | 8 | Sync preamble length, ticks |
| tail_ms_i | input | 8 | Tail phase length, ticks |
| max_tx_ms_i | input | 16 | Key-up limit, ticks |
| pll_data_o | output | 1 | Serial data to synthesizer |
| pll_clk_o | output | 1 | Serial clock to synthesizer |
| pll_en_o | output | 1 | Latch enable to synthesizer |
| key_o | output | 1 | Transmitter key |
| pa_bias_o | output | 1 | Power-amplifier bias enable |
| mod_en_o | output | 1 | Modulation allowed (sync, payload, tail) |
| pay_en_o | output | 1 | Payload passing (payload phase) |
| phase_o | output | 3 | Current phase code |
| phase_stb_o | output | 1 | Phase-change strobe |
| done_o | output | 1 | Burst ended, one clock |
| abort_o | output | 1 | Last burst was forced off |

## Verification
Every output is decoded from, or is, a register that updates on the edge where the phase changes, so each result is visible in the clock right after its cause:
- The load starts one clock after the request is seen.
- A timed phase ends one clock after the tick that empties its counter.
- The tail starts one clock after `data_end_i` is seen.
- Done follows one clock after the key drops.

The bench drives inputs on the falling edge and samples just after it. It ticks every ten clocks, so no tick lands in a phase's final cycle. It measures each timed phase by counting the ticks seen while that phase code is shown, and this count must equal the programmed value exactly. The serial word is rebuilt from data sampled on serial-clock rises and compared to the programmed word.

// File: rtl/tx_key_pkg.sv
package tx_key_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_QUIET  = 3'd3,
    ST_SYNC   = 3'd4,
    ST_DATA   = 3'd5,
    ST_TAIL   = 3'd6
  } tx_state_e;

  function automatic logic key_phase(tx_state_e s);
    return (s == ST_QUIET) || (s == ST_SYNC) || (s == ST_DATA) || (s == ST_TAIL);
  endfunction
endpackage

// File: rtl/txk_pll_shift.sv
module txk_pll_shift #(
  parameter int PLL_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PLL_W-1:0] word_i,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             sle_o,
  output logic             done_o
);
  localparam int CW = $clog2(PLL_W + 1);

  logic [PLL_W-1:0] sreg_q;
  logic [CW-1:0]    bit_q;
  logic             ph_q;
  logic             busy_q;
  logic             latch_slot;

  assign latch_slot = (bit_q == CW'(PLL_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      sreg_q <= word_i;
      bit_q  <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        if (latch_slot) begin
          busy_q <= 1'b0;
        end else begin
          bit_q  <= bit_q + CW'(1);
          sreg_q <= {sreg_q[PLL_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdata_o = busy_q & ~latch_slot & sreg_q[PLL_W-1];
  assign sclk_o  = busy_q & ~latch_slot & ph_q;
  assign sle_o   = busy_q & latch_slot;
  assign done_o  = busy_q & latch_slot & ph_q;

  // R2: data held while serial clock is high
  a_r2_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));
  // R2: latch enable lasts two clocks
  a_r2_le_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sle_o) |=> sle_o);
  a_r2_le_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sle_o && $past(sle_o)) |=> !sle_o);
endmodule

// File: rtl/txk_phase_timer.sv
module txk_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/txk_watchdog.sv
module txk_watchdog #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (tick_i && !expired_o)   cnt_q <= cnt_q + TO_W'(1);
  end
endmodule

// File: rtl/tx_key_seq.sv
module tx_key_seq
  import tx_key_pkg::*;
#(
  parameter int PLL_W = 24,
  parameter int MS_W  = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_ms_i,
  input  logic             req_i,
  input  logic             data_end_i,
  input  logic [PLL_W-1:0] pll_word_i,
  input  logic [MS_W-1:0]  settle_ms_i,
  input  logic [MS_W-1:0]  quiet_ms_i,
  input  logic [MS_W-1:0]  sync_ms_i,
  input  logic [MS_W-1:0]  tail_ms_i,
  input  logic [TO_W-1:0]  max_tx_ms_i,
  output logic             pll_data_o,
  output logic             pll_clk_o,
  output logic             pll_en_o,
  output logic             key_o,
  output logic             pa_bias_o,
  output logic             mod_en_o,
  output logic             pay_en_o,
  output logic [2:0]       phase_o,
  output logic             phase_stb_o,
  output logic             done_o,
  output logic             abort_o
);
  tx_state_e       state_q, state_d;
  logic            lock_q, done_q, abort_q, stb_q;
  logic            sh_start, sh_done, tm_load, tm_exp, wd_exp;
  logic [MS_W-1:0] tm_val;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i && !lock_q) state_d = ST_LOAD;
      ST_LOAD:   if (sh_done)          state_d = ST_SETTLE;
      ST_SETTLE: if (tm_exp)           state_d = ST_QUIET;
      ST_QUIET:  if (tm_exp)           state_d = ST_SYNC;
      ST_SYNC:   if (tm_exp)           state_d = ST_DATA;
      ST_DATA:   if (data_end_i)       state_d = ST_TAIL;
      ST_TAIL:   if (tm_exp)           state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
    if (wd_exp) state_d = ST_IDLE;
  end

  always_comb begin
    unique case (state_d)
      ST_SETTLE: tm_val = settle_ms_i;
      ST_QUIET:  tm_val = quiet_ms_i;
      ST_SYNC:   tm_val = sync_ms_i;
      ST_TAIL:   tm_val = tail_ms_i;
      default:   tm_val = '0;
    endcase
  end

  assign tm_load  = (state_d != state_q);
  assign sh_start = (state_q == ST_IDLE) && (state_d == ST_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= (state_d != state_q);
      done_q  <= key_phase(state_q) && !key_phase(state_d);
      if (wd_exp)        lock_q <= 1'b1;
      else if (!req_i)   lock_q <= 1'b0;
      if (sh_start)      abort_q <= 1'b0;
      else if (wd_exp)   abort_q <= 1'b1;
    end
  end

  txk_pll_shift #(.PLL_W(PLL_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .word_i  (pll_word_i),
    .sdata_o (pll_data_o),
    .sclk_o  (pll_clk_o),
    .sle_o   (pll_en_o),
    .done_o  (sh_done)
  );

  txk_phase_timer #(.CNT_W(MS_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .tick_i     (tick_ms_i),
    .expired_o  (tm_exp)
  );

  txk_watchdog #(.TO_W(TO_W)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (key_o),
    .tick_i    (tick_ms_i),
    .limit_i   (max_tx_ms_i),
    .expired_o (wd_exp)
  );

  assign key_o       = key_phase(state_q);
  assign pa_bias_o   = key_o;
  assign mod_en_o    = (state_q == ST_SYNC) || (state_q == ST_DATA) || (state_q == ST_TAIL);
  assign pay_en_o    = (state_q == ST_DATA);
  assign phase_o     = state_q;
  assign phase_stb_o = stb_q;
  assign done_o      = done_q;
  assign abort_o     = abort_q;

  // R3: key rises only out of settle
  a_r3_key_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_o) |-> $past(state_q) == ST_SETTLE);
  // R6: payload follows sync
  a_r6_pay_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pay_en_o) |-> $past(state_q) == ST_SYNC);
  // R7: done in first key-low cycle
  a_r7_done_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!key_o && $past(key_o)));
  // R8: watchdog expiry forces key off
  a_r8_forced_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp |=> !key_o);
  // R9: locked sequencer stays idle
  a_r9_locked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && lock_q) |=> state_q == ST_IDLE);
  // R10: strobe only on phase change
  a_r10_stb_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_stb_o |-> state_q != $past(state_q));
endmodule

// File: tb/tx_key_seq_tb.sv
module tx_key_seq_tb;
  localparam int TICK = 10;

  typedef struct packed {
    logic [23:0] word;
    logic [7:0]  settle;
    logic [7:0]  quiet;
    logic [7:0]  sync;
    logic [7:0]  tail;
    logic [7:0]  dticks;
    logic [15:0] maxto;
    logic        exp_abort;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{24'hA5C3F0, 8'd2, 8'd5, 8'd12, 8'd5, 8'd3, 16'd200, 1'b0},
    '{24'h800001, 8'd1, 8'd1, 8'd1,  8'd1, 8'd1, 16'd100, 1'b0},
    '{24'h3C5A96, 8'd3, 8'd2, 8'd11, 8'd4, 8'd6, 16'd9,   1'b1},
    '{24'h13579B, 8'd2, 8'd6, 8'd13, 8'd7, 8'd2, 16'd20,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, req = 1'b0, dend = 1'b0;
  logic [23:0] word = '0;
  logic [7:0]  settle = 8'd1, quiet = 8'd1, syncv = 8'd1, tail = 8'd1;
  logic [15:0] maxto = 16'd100;
  logic pdata, pclk, pen, key, bias, moden, payen, stb, done, abrt;
  logic [2:0] phase;

  int total = 0, bad = 0;
  int ph_ticks [8];
  int key_ticks, load_cyc, bits, le_cyc, done_cnt, done_abort, done_key_bad;
  int stb_cnt, stb_bad, bias_bad, mod_bad;
  logic [23:0] cap;
  logic [2:0]  prev_phase = 3'd0;
  logic        prev_clk = 1'b0;

  always #5 clk = ~clk;

  tx_key_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .req_i(req), .data_end_i(dend),
    .pll_word_i(word), .settle_ms_i(settle), .quiet_ms_i(quiet), .sync_ms_i(syncv),
    .tail_ms_i(tail), .max_tx_ms_i(maxto),
    .pll_data_o(pdata), .pll_clk_o(pclk), .pll_en_o(pen), .key_o(key), .pa_bias_o(bias),
    .mod_en_o(moden), .pay_en_o(payen), .phase_o(phase), .phase_stb_o(stb),
    .done_o(done), .abort_o(abrt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 8; i++) ph_ticks[i] = 0;
    key_ticks = 0; load_cyc = 0; bits = 0; le_cyc = 0; done_cnt = 0; done_abort = 0;
    done_key_bad = 0; stb_cnt = 0; stb_bad = 0; bias_bad = 0; mod_bad = 0; cap = '0;
  endtask

  initial begin
    forever begin
      repeat (TICK - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial begin
    clr();
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (tick) ph_ticks[phase]++;
        if (tick && key) key_ticks++;
        if (phase == 3'd1) load_cyc++;
        if (pclk && !prev_clk && !pen) begin
          cap = {cap[22:0], pdata};
          bits++;
        end
        if (pen) begin
          le_cyc++;
          if (pdata) mod_bad++;
        end
        if (done) begin
          done_cnt++;
          done_abort = int'(abrt);
          if (key) done_key_bad++;
        end
        if (stb) stb_cnt++;
        if (stb != (phase != prev_phase)) stb_bad++;
        if (bias != key) bias_bad++;
        if (moden != (phase == 3'd4 || phase == 3'd5 || phase == 3'd6)) mod_bad++;
        if (payen != (phase == 3'd5)) mod_bad++;
        if (key && phase == 3'd3 && moden) mod_bad++;
        prev_phase = phase;
        prev_clk = pclk;
      end
    end
  end

  task automatic setp(input vec_t v);
    word = v.word; settle = v.settle; quiet = v.quiet; syncv = v.sync;
    tail = v.tail; maxto = v.maxto;
  endtask

  task automatic start_burst(input vec_t v);
    @(negedge clk);
    clr();
    setp(v);
    req = 1'b1;
    @(negedge clk);
    while (phase == 3'd0) @(negedge clk);
  endtask

  task automatic finish_burst(input int dticks);
    while (phase != 3'd5 && done_cnt == 0) @(negedge clk);
    if (done_cnt == 0) begin
      repeat (dticks * TICK) @(negedge clk);
      if (done_cnt == 0) begin
        dend = 1'b1;
        @(negedge clk);
        dend = 1'b0;
      end
    end
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 key", int'(key), 0);
    chk("R1 serial", int'(pdata | pclk | pen), 0);
    chk("R1 flags", int'(done | abrt | stb | moden | payen | bias), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", int'(phase), 0);

    // table walk
    for (int i = 0; i < 4; i++) begin
      start_burst(VECS[i]);
      req = 1'b0;
      finish_burst(int'(VECS[i].dticks));
      chk("R2 word", int'(cap), int'(VECS[i].word));
      chk("R2 bits", bits, 24);
      chk("R2 latch cycles", le_cyc, 2);
      chk("R2 load cycles", load_cyc, 50);
      chk("R3 settle ticks", ph_ticks[2], int'(VECS[i].settle));
      chk("R4 quiet ticks", ph_ticks[3], int'(VECS[i].quiet));
      chk("R10 strobe", stb_bad, 0);
      chk("R11 bias", bias_bad, 0);
      chk("R4 R5 R6 modulation gating", mod_bad, 0);
      chk("R7 done once", done_cnt, 1);
      chk("R7 done key low", done_key_bad, 0);
      if (VECS[i].exp_abort) begin
        chk("R8 abort flag", done_abort, 1);
        chk("R8 key ticks", key_ticks, int'(VECS[i].maxto));
      end else begin
        chk("R5 sync ticks", ph_ticks[4], int'(VECS[i].sync));
        chk("R7 tail ticks", ph_ticks[6], int'(VECS[i].tail));
        chk("R7 abort flag", done_abort, 0);
        chk("R10 strobe count", stb_cnt, 7);
        chk("R8 key ticks sum", key_ticks,
            int'(VECS[i].quiet) + int'(VECS[i].sync) + ph_ticks[5] + int'(VECS[i].tail));
      end
      repeat (5) @(negedge clk);
    end

    // R9 request during burst ignored
    start_burst(VECS[1]);
    req = 1'b0;
    while (phase != 3'd4) @(negedge clk);
    req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    finish_burst(1);
    repeat (20) @(negedge clk);
    chk("R9 ignored req phase", int'(phase), 0);
    chk("R9 ignored req strobes", stb_cnt, 7);

    // R9 level request retriggers after normal end
    start_burst(VECS[1]);
    finish_burst(1);
    chk("R9 retrigger", int'(phase), 1);
    req = 1'b0;
    clr();
    finish_burst(1);
    chk("R9 retrigger burst end", done_abort, 0);
    repeat (5) @(negedge clk);

    // R9 after abort, held request does not restart
    start_burst(VECS[2]);
    finish_burst(6);
    chk("R8 abort held req", done_abort, 1);
    repeat (60) @(negedge clk);
    chk("R9 locked idle", int'(phase), 0);
    req = 1'b0;
    repeat (2) @(negedge clk);
    req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 fresh edge starts", int'(phase), 1);
    req = 1'b0;
    clr();
    finish_burst(6);
    chk("R8 second abort", done_abort, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule